// File: doc/BRIEF.md
# Modem Control Loopback Switch

This block sits between one serial channel and its modem-control pins. It holds the channel's five-bit modem control word and builds the eight-bit modem status word. It also routes the serial data line, either to the outside world or back into the channel's own receiver. In normal operation the status levels come from the four active-low status pins (clear-to-send, data-set-ready, ring indicator, carrier detect). The four control bits drive the active-low output pins, and the serial transmit and receive lines pass straight through.

Setting the loopback bit turns the block into a self-test harness. The external status pins and the receive pin are no longer heard. Each control bit feeds one internal status line, and the transmit stream from the serializer is handed directly to the deserializer. While this is happening, the transmit pin idles high and the control pins sit inactive. The change detection and the modem-status interrupt behave identically in both modes, so a diagnostic routine can exercise the whole interrupt path by writing control bits alone.

The status levels pass through a parameterised synchronizer before they are compared with their previous value to raise the change flags. A status read clears those flags.

Top module: `mdm_loop_switch`

## Requirements
- R1: Synchronous active-high reset clears the control word to 0, the four status levels to 0 and the four change flags to 0, and it drops the interrupt.
- R2: With control bit 4 clear, pin_dtr_n, pin_rts_n, pin_op1_n and pin_op2_n equal the inverse of control bits 0, 1, 2 and 3. pin_tx equals ser_tx_in and ser_rx_out equals pin_rx, combinationally.
- R3: With control bit 4 clear, status bits 4, 5, 6 and 7 show the inverse of pin_cts_n, pin_dsr_n, pin_ri_n and pin_cd_n, SYNC_STAGES clock edges after the pin is sampled.
- R4: Control bit 4 is the loopback enable. While it is set, pin_tx and all four control pins are held at 1.
- R5: In loopback, status bit 4 follows control bit 0, bit 5 follows control bit 1, bit 6 follows control bit 2 and bit 7 follows control bit 3, with the same synchronizer delay. The four external status pins have no effect.
- R6: In loopback, ser_rx_out equals ser_tx_in and pin_rx has no effect.
- R7: Status bits 0, 1 and 3 are set on the edge after status bit 4, 5 or 7 changes in either direction. Once set, they stay set until a read.
- R8: Status bit 2 is set only when status bit 6 goes from 1 to 0, and not when it goes from 0 to 1.
- R9: An edge with msr_rd_en high clears the change flags, except that a change detected on that same edge sets its flag.
- R10: ms_irq is high exactly when any of status bits 0 to 3 is set and ms_irq_en is high, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_wr_en | input | 1 | Load the control word |
| mcr_wdata | input | 5 | New control word: bit0 DTR, bit1 RTS, bit2 OP1, bit3 OP2, bit4 loopback |
| mcr_rdata | output | 5 | Current control word |
| msr_rd_en | input | 1 | Status read strobe; clears the change flags |
| msr_rdata | output | 8 | Status word: bits 7..4 CD, RI, DSR, CTS levels; bits 3..0 change flags |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| ms_irq | output | 1 | Modem-status interrupt |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_ri_n | input | 1 | Ring indicator pin, active low |
| pin_cd_n | input | 1 | Carrier detect pin, active low |
| pin_dtr_n | output | 1 | Data-terminal-ready pin, active low |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| pin_op1_n | output | 1 | User output 1 pin, active low |
| pin_op2_n | output | 1 | User output 2 pin, active low |
| ser_tx_in | input | 1 | Serial stream from the serializer |
| pin_tx | output | 1 | Transmit pin |
| pin_rx | input | 1 | Receive pin |
| ser_rx_out | output | 1 | Serial stream to the deserializer |

## Verification
The hardest case to reach is a status read that lands on the same edge as a new change event, because the event only emerges after the synchronizer delay. The stimulus holds the read strobe high across several edges after a control write in loopback, so the event edge falls inside the read window. A second awkward case is an ignored input: the bench toggles the external status pins and the receive pin during loopback while comparing every output each cycle. A long pseudo-random phase then mixes mode switches, pin changes, reads and enable changes.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    typedef struct packed {
        logic loop_en;
        logic op2;
        logic op1;
        logic rts;
        logic dtr;
    } mcr_t;

    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    localparam int MCR_W   = $bits(mcr_t);
    localparam int LINES_W = $bits(mdm_lines_t);
    localparam int MSR_W   = 2 * LINES_W;

    function automatic mdm_lines_t lines_from_pins(input logic cts_n, input logic dsr_n,
                                                   input logic ri_n, input logic cd_n);
        mdm_lines_t l;
        l.cts = ~cts_n;
        l.dsr = ~dsr_n;
        l.ri  = ~ri_n;
        l.cd  = ~cd_n;
        return l;
    endfunction

    function automatic mdm_lines_t lines_from_mcr(input mcr_t m);
        mdm_lines_t l;
        l.cts = m.dtr;
        l.dsr = m.rts;
        l.ri  = m.op1;
        l.cd  = m.op2;
        return l;
    endfunction

    function automatic mdm_lines_t line_events(input mdm_lines_t prev, input mdm_lines_t cur);
        mdm_lines_t e;
        e.cts = prev.cts ^ cur.cts;
        e.dsr = prev.dsr ^ cur.dsr;
        e.ri  = prev.ri & ~cur.ri;
        e.cd  = prev.cd ^ cur.cd;
        return e;
    endfunction

endpackage

// File: rtl/mdm_route.sv
module mdm_route
    import mdm_pkg::*;
(
    input  mcr_t       mcr,
    input  logic       pin_cts_n,
    input  logic       pin_dsr_n,
    input  logic       pin_ri_n,
    input  logic       pin_cd_n,
    input  logic       ser_tx_in,
    input  logic       pin_rx,
    output mdm_lines_t src_lines,
    output logic       pin_dtr_n,
    output logic       pin_rts_n,
    output logic       pin_op1_n,
    output logic       pin_op2_n,
    output logic       pin_tx,
    output logic       ser_rx_out
);
    always_comb begin
        if (mcr.loop_en) begin
            src_lines  = lines_from_mcr(mcr);
            pin_dtr_n  = 1'b1;
            pin_rts_n  = 1'b1;
            pin_op1_n  = 1'b1;
            pin_op2_n  = 1'b1;
            pin_tx     = 1'b1;
            ser_rx_out = ser_tx_in;
        end else begin
            src_lines  = lines_from_pins(pin_cts_n, pin_dsr_n, pin_ri_n, pin_cd_n);
            pin_dtr_n  = ~mcr.dtr;
            pin_rts_n  = ~mcr.rts;
            pin_op1_n  = ~mcr.op1;
            pin_op2_n  = ~mcr.op2;
            pin_tx     = ser_tx_in;
            ser_rx_out = pin_rx;
        end
    end
endmodule

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= '0;
            else     st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  mdm_lines_t       src_lines,
    input  logic             rd_en,
    input  logic             irq_en,
    output logic [MSR_W-1:0] msr,
    output logic             irq
);
    mdm_lines_t lvl, prev, delta, ev;

    mdm_sync #(.W(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_lines),
        .q   (lvl)
    );

    assign ev = line_events(prev, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            delta <= '0;
        end else begin
            prev  <= lvl;
            delta <= (rd_en ? mdm_lines_t'('0) : delta) | ev;
        end
    end

    assign msr = {lvl, delta};
    assign irq = irq_en & (|delta);
endmodule

// File: rtl/mdm_loop_switch.sv
module mdm_loop_switch
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mcr_wr_en,
    input  logic [MCR_W-1:0] mcr_wdata,
    output logic [MCR_W-1:0] mcr_rdata,
    input  logic             msr_rd_en,
    output logic [MSR_W-1:0] msr_rdata,
    input  logic             ms_irq_en,
    output logic             ms_irq,
    input  logic             pin_cts_n,
    input  logic             pin_dsr_n,
    input  logic             pin_ri_n,
    input  logic             pin_cd_n,
    output logic             pin_dtr_n,
    output logic             pin_rts_n,
    output logic             pin_op1_n,
    output logic             pin_op2_n,
    input  logic             ser_tx_in,
    output logic             pin_tx,
    input  logic             pin_rx,
    output logic             ser_rx_out
);
    mcr_t       mcr_q;
    mdm_lines_t src_lines;

    always_ff @(posedge clk) begin
        if (rst)            mcr_q <= '0;
        else if (mcr_wr_en) mcr_q <= mcr_t'(mcr_wdata);
    end

    assign mcr_rdata = mcr_q;

    mdm_route u_route (
        .mcr        (mcr_q),
        .pin_cts_n  (pin_cts_n),
        .pin_dsr_n  (pin_dsr_n),
        .pin_ri_n   (pin_ri_n),
        .pin_cd_n   (pin_cd_n),
        .ser_tx_in  (ser_tx_in),
        .pin_rx     (pin_rx),
        .src_lines  (src_lines),
        .pin_dtr_n  (pin_dtr_n),
        .pin_rts_n  (pin_rts_n),
        .pin_op1_n  (pin_op1_n),
        .pin_op2_n  (pin_op2_n),
        .pin_tx     (pin_tx),
        .ser_rx_out (ser_rx_out)
    );

    mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
        .clk       (clk),
        .rst       (rst),
        .src_lines (src_lines),
        .rd_en     (msr_rd_en),
        .irq_en    (ms_irq_en),
        .msr       (msr_rdata),
        .irq       (ms_irq)
    );
endmodule

// File: rtl/mdm_loop_chk.sv
module mdm_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] mcr_rdata,
    input logic       msr_rd_en,
    input logic [7:0] msr_rdata,
    input logic       ms_irq_en,
    input logic       ms_irq,
    input logic       pin_dtr_n,
    input logic       pin_rts_n,
    input logic       pin_op1_n,
    input logic       pin_op2_n,
    input logic       ser_tx_in,
    input logic       pin_tx,
    input logic       ser_rx_out
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (msr_rdata[3:0] == 4'b0 && mcr_rdata == 5'b0));

    assert_loop_pins_idle_R4: assert property (@(posedge clk) disable iff (rst)
        mcr_rdata[4] |-> (pin_tx && pin_dtr_n && pin_rts_n && pin_op1_n && pin_op2_n));

    assert_loop_serial_R6: assert property (@(posedge clk) disable iff (rst)
        mcr_rdata[4] |-> (ser_rx_out == ser_tx_in));

    assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !msr_rd_en |=> ((msr_rdata[3:0] & $past(msr_rdata[3:0])) == $past(msr_rdata[3:0])));

    assert_ri_falling_only_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(msr_rdata[2]) |-> ($past(msr_rdata[6]) && !msr_rdata[6]) || $fell($past(msr_rdata[6])));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        ms_irq == (ms_irq_en && (msr_rdata[3:0] != 4'b0)));
endmodule

bind mdm_loop_switch mdm_loop_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mcr_rdata  (mcr_rdata),
    .msr_rd_en  (msr_rd_en),
    .msr_rdata  (msr_rdata),
    .ms_irq_en  (ms_irq_en),
    .ms_irq     (ms_irq),
    .pin_dtr_n  (pin_dtr_n),
    .pin_rts_n  (pin_rts_n),
    .pin_op1_n  (pin_op1_n),
    .pin_op2_n  (pin_op2_n),
    .ser_tx_in  (ser_tx_in),
    .pin_tx     (pin_tx),
    .ser_rx_out (ser_rx_out)
);

// File: tb/sim_mdm_loop_switch.sv
module sim_mdm_loop_switch;
    localparam int STAGES = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mcr_wr_en = 1'b0;
    logic [4:0] mcr_wdata = 5'b0;
    logic [4:0] mcr_rdata;
    logic msr_rd_en = 1'b0;
    logic [7:0] msr_rdata;
    logic ms_irq_en = 1'b0;
    logic ms_irq;
    logic pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_ri_n = 1'b1, pin_cd_n = 1'b1;
    logic pin_dtr_n, pin_rts_n, pin_op1_n, pin_op2_n;
    logic ser_tx_in = 1'b1, pin_tx, pin_rx = 1'b1, ser_rx_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mdm_loop_switch #(.SYNC_STAGES(STAGES)) u0 (
        .clk(clk), .rst(rst), .mcr_wr_en(mcr_wr_en), .mcr_wdata(mcr_wdata),
        .mcr_rdata(mcr_rdata), .msr_rd_en(msr_rd_en), .msr_rdata(msr_rdata),
        .ms_irq_en(ms_irq_en), .ms_irq(ms_irq), .pin_cts_n(pin_cts_n),
        .pin_dsr_n(pin_dsr_n), .pin_ri_n(pin_ri_n), .pin_cd_n(pin_cd_n),
        .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n), .pin_op1_n(pin_op1_n),
        .pin_op2_n(pin_op2_n), .ser_tx_in(ser_tx_in), .pin_tx(pin_tx),
        .pin_rx(pin_rx), .ser_rx_out(ser_rx_out)
    );

    // Behavioural reference model
    logic [4:0] m_mcr;
    logic [3:0] m_pipe[$];
    logic [3:0] m_prev, m_flags, m_lvl, m_ev, m_src;

    always @(posedge clk) begin
        if (rst) begin
            m_mcr = 5'b0;
            m_pipe.delete();
            for (int i = 0; i < STAGES; i++) m_pipe.push_back(4'b0);
            m_prev = 4'b0;
            m_flags = 4'b0;
        end else begin
            m_lvl = m_pipe[0];
            m_ev[0] = m_lvl[0] != m_prev[0];
            m_ev[1] = m_lvl[1] != m_prev[1];
            m_ev[2] = m_prev[2] && !m_lvl[2];
            m_ev[3] = m_lvl[3] != m_prev[3];
            m_flags = (msr_rd_en ? 4'b0 : m_flags) | m_ev;
            m_prev = m_lvl;
            if (m_mcr[4]) m_src = m_mcr[3:0];
            else          m_src = {!pin_cd_n, !pin_ri_n, !pin_dsr_n, !pin_cts_n};
            void'(m_pipe.pop_front());
            m_pipe.push_back(m_src);
            if (mcr_wr_en) m_mcr = mcr_wdata;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (m_pipe.size() == STAGES) begin
            chk("R1/R2/R4 control word", {3'b0, mcr_rdata}, {3'b0, m_mcr});
            chk("R3/R5 status levels", {4'b0, msr_rdata[7:4]}, {4'b0, m_pipe[0]});
            chk("R7/R8/R9 change flags", {4'b0, msr_rdata[3:0]}, {4'b0, m_flags});
            chk("R10 interrupt", {7'b0, ms_irq}, {7'b0, ms_irq_en && (m_flags != 4'b0)});
            if (m_mcr[4]) begin
                chk("R4 pins idle", {3'b0, pin_tx, pin_op2_n, pin_op1_n, pin_rts_n, pin_dtr_n},
                    8'h1f);
                chk("R6 serial loop", {7'b0, ser_rx_out}, {7'b0, ser_tx_in});
            end else begin
                chk("R2 pins", {3'b0, pin_tx, pin_op2_n, pin_op1_n, pin_rts_n, pin_dtr_n},
                    {3'b0, ser_tx_in, ~m_mcr[3:0]});
                chk("R2 serial pass", {7'b0, ser_rx_out}, {7'b0, pin_rx});
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mcr(input logic [4:0] v);
        mcr_wr_en = 1'b1;
        mcr_wdata = v;
        cyc(1);
        mcr_wr_en = 1'b0;
    endtask

    task automatic rd_msr();
        msr_rd_en = 1'b1;
        cyc(1);
        msr_rd_en = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 reset status", msr_rdata, 8'h00);
        // R3 normal pin levels and R7 changes
        pin_cts_n = 1'b0; cyc(4);
        chk("R3 cts level", {7'b0, msr_rdata[4]}, 8'h01);
        chk("R7 cts flag", {7'b0, msr_rdata[0]}, 8'h01);
        rd_msr(); cyc(1);
        chk("R9 read clears", {4'b0, msr_rdata[3:0]}, 8'h00);
        pin_dsr_n = 1'b0; pin_cd_n = 1'b0; pin_ri_n = 1'b0; cyc(4);
        chk("R8 ri rise no flag", {7'b0, msr_rdata[2]}, 8'h00);
        rd_msr();
        pin_ri_n = 1'b1; cyc(4);
        chk("R8 ri fall flag", {7'b0, msr_rdata[2]}, 8'h01);
        ms_irq_en = 1'b1; cyc(1);
        chk("R10 irq on", {7'b0, ms_irq}, 8'h01);
        rd_msr();
        // R2 normal outputs and serial path
        wr_mcr(5'b0_0101);
        ser_tx_in = 1'b0; pin_rx = 1'b0; cyc(2);
        ser_tx_in = 1'b1; cyc(2);
        // R4/R5/R6 loopback
        wr_mcr(5'b1_0101); cyc(4);
        chk("R5 loop levels", {4'b0, msr_rdata[7:4]}, 8'h05);
        rd_msr();
        pin_cts_n = 1'b1; pin_dsr_n = 1'b1; pin_cd_n = 1'b1; pin_ri_n = 1'b0; pin_rx = 1'b1;
        cyc(4);
        chk("R5 pins ignored", {4'b0, msr_rdata[3:0]}, 8'h00);
        ser_tx_in = 1'b0; cyc(1);
        chk("R6 loop serial", {7'b0, ser_rx_out}, 8'h00);
        ser_tx_in = 1'b1;
        // R9 read overlapping a new event (op1 falls -> ri trailing)
        wr_mcr(5'b1_0001);
        msr_rd_en = 1'b1; cyc(5); msr_rd_en = 1'b0;
        wr_mcr(5'b1_1110); cyc(4);
        chk("R10 loop irq", {7'b0, ms_irq}, 8'h01);
        // pseudo-random mix
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pin_cts_n = lfsr[0]; pin_dsr_n = lfsr[3]; pin_ri_n = lfsr[5]; pin_cd_n = lfsr[7];
            ser_tx_in = lfsr[9]; pin_rx = lfsr[11];
            msr_rd_en = lfsr[2] & lfsr[6];
            ms_irq_en = lfsr[14] | lfsr[1];
            mcr_wr_en = (lfsr[4:3] == 2'b11);
            mcr_wdata = {lfsr[15] & lfsr[8], lfsr[12], lfsr[10], lfsr[13], lfsr[1]};
            cyc(1);
        end
        mcr_wr_en = 1'b0; msr_rd_en = 1'b0;
        cyc(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule